// File: doc/BRIEF.md
# Conditional Stream Compaction Unit

This unit sits between a row of parallel SIMD lanes and a stream buffer. In each input beat, every lane offers one data value and a one-bit case flag. Values whose flag is 1 go to the "hit" output stream. They are packed densely: lane order is kept within a beat and arrival order is kept across beats. A value whose flag is 0 is either dropped or, when splitting is enabled, packed the same way onto a second "miss" stream. The input is split into two homogeneous streams, and no lane ever holds an idle masked slot.

Values that do not fill a whole output word are held back and merged with later beats, so both outputs normally emit full-width words. A beat marked as a flush pushes out whatever is left, and the last word then carries a count of its valid slots.

Each stream interface is valid/ready. A beat or word transfers on a rising clock edge where both valid and ready are high. Once a producer raises valid, it must hold the data until that edge. When either output stalls far enough that the next beat could not be stored, the unit lowers `in_ready` instead of losing elements. `in_ready` depends combinationally on the two output ready signals. This lets a word leave and a new beat enter in the same cycle.

Top module: `cond_stream_compact`

## Requirements
- R1: After reset, both output valids are low and `in_ready` is high.
- R2: A value in lane i sits at bits [i*DW +: DW] of `in_data`, and output slot j sits at bits [j*DW +: DW] of a word. Every value with case 1 appears exactly once on the hit stream, from slot 0 upward. The order is lane index within a beat and then beat order.
- R3: Without a flush, every hit or miss word carries `LANES` valid values and its count is `LANES`. Leftover values wait inside the unit for later beats.
- R4: With `split_en` high, every value with case 0 appears exactly once on the miss stream, under the same ordering and packing rules as R2 and R3.
- R5: With `split_en` low, values with case 0 are discarded and `f_valid` stays low; a beat whose flags are all 0 produces no output at all.
- R6: When a beat with `in_flush` high is accepted, everything that stream holds is emitted. The last word may be partial, and its count (binary, 1 to `LANES`) gives the number of valid slots from slot 0. If more than one word is held, a full word goes out first. A flush with nothing held emits nothing. Input is refused until the drain finishes.
- R7: While an output has valid high and ready low, its data and count stay unchanged. `in_ready` drops rather than accept a beat that could not be stored, so no value is lost.
- R8: With both output readies held high, every beat without a flush is accepted in the cycle it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| split_en | input | 1 | Route case-0 values to the miss stream (keep static while traffic flows) |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | LANES*DW | One value per lane, lane 0 in the low bits |
| in_case | input | LANES | Case flag per lane |
| in_flush | input | 1 | Beat closes the stream; drain residue afterwards |
| t_valid | output | 1 | Hit word available |
| t_ready | input | 1 | Hit consumer accepts |
| t_data | output | LANES*DW | Packed hit values, slot 0 in the low bits |
| t_count | output | $clog2(LANES+1) | Valid slots in the hit word |
| f_valid | output | 1 | Miss word available |
| f_ready | input | 1 | Miss consumer accepts |
| f_data | output | LANES*DW | Packed miss values, slot 0 in the low bits |
| f_count | output | $clog2(LANES+1) | Valid slots in the miss word |

## Verification
The bench targets residue carry-over across beats of uneven population. A design that mis-indexed the merge would reorder or duplicate values at word boundaries. It also covers flushes holding zero values, exactly one word, and a word plus seven values; a wrong drain would emit an empty word, emit a short first word, or strand the tail. Under random back-pressure, the bench checks that stalled words stay frozen and that the input stalls instead of overwriting buffered values. With split off, it checks that all-zero beats leave both outputs silent.

// File: rtl/csc_pkg.sv
package csc_pkg;
  // Which partition of the lane flags a packer collects
  typedef enum logic {
    CSC_HIT  = 1'b0,
    CSC_MISS = 1'b1
  } csc_sel_e;
endpackage

// File: rtl/csc_compact.sv
// Packs the masked lanes of one beat to the low slots, keeping lane order.
module csc_compact #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES-1:0]    mask,
  output logic [LANES*DW-1:0] packed_w,
  output logic [CW-1:0]       num
);
  always_comb begin
    int pos;
    pos = 0;
    packed_w = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) begin
        packed_w[pos*DW +: DW] = data[i*DW +: DW];
        pos = pos + 1;
      end
    end
    num = CW'(pos);
  end
endmodule

// File: rtl/csc_packer.sv
// One output stream: residue buffer of 2*LANES entries, word out, flush drain.
module csc_packer
  import csc_pkg::*;
#(
  parameter int       LANES = 8,
  parameter int       DW    = 16,
  parameter csc_sel_e SEL   = CSC_HIT,
  localparam int DEPTH = 2 * LANES,
  localparam int BW    = $clog2(DEPTH),
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                split_en,
  input  logic                push,
  input  logic                push_flush,
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES-1:0]    cases,
  output logic                can_take,
  output logic                o_valid,
  input  logic                o_ready,
  output logic [LANES*DW-1:0] o_data,
  output logic [CW-1:0]       o_count
);
  logic [DW-1:0]       buf_q [DEPTH];
  logic [DW-1:0]       buf_d [DEPTH];
  logic [BW-1:0]       cnt_q, cnt_d, cnt_a, pop_n;
  logic                flush_q, flush_d;
  logic [LANES-1:0]    mask;
  logic [LANES*DW-1:0] packed_w;
  logic [CW-1:0]       num;
  logic                pop;

  assign mask = (SEL == CSC_HIT) ? cases : (~cases & {LANES{split_en}});

  csc_compact #(.LANES(LANES), .DW(DW)) u_compact (
    .data(data), .mask(mask), .packed_w(packed_w), .num(num)
  );

  assign o_valid = (cnt_q >= BW'(LANES)) || (flush_q && (cnt_q != '0));
  assign o_count = (cnt_q >= BW'(LANES)) ? CW'(LANES) : CW'(cnt_q);

  for (genvar j = 0; j < LANES; j++) begin : g_out
    assign o_data[j*DW +: DW] = buf_q[j];
  end

  assign pop      = o_valid && o_ready;
  assign pop_n    = pop ? BW'(o_count) : '0;
  assign cnt_a    = cnt_q - pop_n;
  assign can_take = !flush_q && (cnt_a < BW'(LANES));

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      buf_d[e] = ((e + int'(pop_n)) < DEPTH) ? buf_q[e + int'(pop_n)] : '0;
      if (push && (e >= int'(cnt_a)) && (e < int'(cnt_a) + int'(num)))
        buf_d[e] = packed_w[(e - int'(cnt_a))*DW +: DW];
    end
    cnt_d = cnt_a + (push ? BW'(num) : '0);
    if (push && push_flush)
      flush_d = (cnt_d != '0);
    else if (flush_q && (cnt_d == '0))
      flush_d = 1'b0;
    else
      flush_d = flush_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) buf_q[e] <= buf_d[e];
  end

  // R7: a stalled word is frozen
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_count));
  // R7: parent never pushes a beat this stream cannot store
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> can_take);
  // R6: short words only while draining after a flush
  assert_partial_only_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && (o_count < CW'(LANES)) |-> flush_q);
  // R3: an emitted word carries between one and LANES values
  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_count != '0) && (o_count <= CW'(LANES)));
endmodule

// File: rtl/cond_stream_compact.sv
module cond_stream_compact
  import csc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                split_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_case,
  input  logic                in_flush,
  output logic                t_valid,
  input  logic                t_ready,
  output logic [LANES*DW-1:0] t_data,
  output logic [CW-1:0]       t_count,
  output logic                f_valid,
  input  logic                f_ready,
  output logic [LANES*DW-1:0] f_data,
  output logic [CW-1:0]       f_count
);
  localparam int NS = 2;

  logic [NS-1:0]       s_valid, s_ready, s_take, s_push;
  logic [LANES*DW-1:0] s_data  [NS];
  logic [CW-1:0]       s_count [NS];
  logic                accept;

  assign in_ready = s_take[0] && (s_take[1] || !split_en);
  assign accept   = in_valid && in_ready;
  assign s_ready  = {f_ready, t_ready};

  for (genvar g = 0; g < NS; g++) begin : g_pk
    assign s_push[g] = accept && ((g == 0) || split_en);
    csc_packer #(
      .LANES(LANES), .DW(DW), .SEL((g == 0) ? CSC_HIT : CSC_MISS)
    ) u_pk (
      .clk(clk), .rst_n(rst_n), .split_en(split_en),
      .push(s_push[g]), .push_flush(in_flush),
      .data(in_data), .cases(in_case),
      .can_take(s_take[g]),
      .o_valid(s_valid[g]), .o_ready(s_ready[g]),
      .o_data(s_data[g]), .o_count(s_count[g])
    );
  end

  assign t_valid = s_valid[0];
  assign t_data  = s_data[0];
  assign t_count = s_count[0];
  assign f_valid = s_valid[1];
  assign f_data  = s_data[1];
  assign f_count = s_count[1];

  // R5: with splitting off the miss stream stays silent
  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !split_en && !f_valid |=> !f_valid);
endmodule

// File: tb/tb_cond_stream_compact.sv
`timescale 1ns/1ps
module tb_cond_stream_compact;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int CW    = $clog2(LANES + 1);

  logic clk = 1'b0, rst_n = 1'b0, split_en = 1'b0;
  logic in_valid = 1'b0, in_flush = 1'b0, in_ready;
  logic [LANES*DW-1:0] in_data = '0;
  logic [LANES-1:0] in_case = '0;
  logic t_valid, f_valid, t_ready = 1'b0, f_ready = 1'b0;
  logic [LANES*DW-1:0] t_data, f_data;
  logic [CW-1:0] t_count, f_count;

  always #10 clk = ~clk;

  cond_stream_compact #(.LANES(LANES), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .split_en(split_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_case(in_case), .in_flush(in_flush),
    .t_valid(t_valid), .t_ready(t_ready), .t_data(t_data), .t_count(t_count),
    .f_valid(f_valid), .f_ready(f_ready), .f_data(f_data), .f_count(f_count)
  );

  int checks = 0, errors = 0;
  int rmode = 1;            // 0 random ready, 1 always ready, 2 never ready
  logic [DW-1:0] exp_q0[$], exp_q1[$];
  bit flushed[2];
  bit held[2];
  logic [LANES*DW-1:0] held_d[2];
  logic [CW-1:0] held_c[2];
  logic [DW-1:0] seq = 16'h0100;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_stream(input int s, input logic v, input logic r,
                              input logic [LANES*DW-1:0] d, input logic [CW-1:0] c);
    if (held[s]) begin
      chk(v && d == held_d[s] && c == held_c[s], "R7", "stalled word changed",
          longint'(d[63:0]), longint'(held_d[s][63:0]));
    end
    if (s == 1 && !split_en) chk(!v, "R5", "miss stream valid with split off", v, 0);
    if (v && r) begin
      if (int'(c) != LANES)
        chk(flushed[s] && ((s == 0 ? exp_q0.size() : exp_q1.size()) == int'(c)),
            "R6", "short word outside flush drain", c, LANES);
      else chk(1'b1, "R3", "full word count", c, LANES);
      for (int j = 0; j < int'(c); j++) begin
        logic [DW-1:0] e;
        if ((s == 0 ? exp_q0.size() : exp_q1.size()) == 0) begin
          chk(1'b0, s == 0 ? "R2" : "R4", "unexpected extra value", d[j*DW +: DW], 0);
        end else begin
          e = (s == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
          chk(d[j*DW +: DW] == e, s == 0 ? "R2" : "R4", "slot value", d[j*DW +: DW], e);
        end
      end
      if ((s == 0 ? exp_q0.size() : exp_q1.size()) == 0) flushed[s] = 1'b0;
    end
    held[s]   = v && !r;
    held_d[s] = d;
    held_c[s] = c;
  endtask

  // Monitor: picks readies at the falling edge, then judges the coming transfer
  initial begin
    forever begin
      @(negedge clk);
      case (rmode)
        0: begin t_ready = $urandom_range(0, 1) == 1; f_ready = $urandom_range(0, 1) == 1; end
        1: begin t_ready = 1'b1; f_ready = 1'b1; end
        default: begin t_ready = 1'b0; f_ready = 1'b0; end
      endcase
      #1;
      if (rst_n) begin
        check_stream(0, t_valid, t_ready, t_data, t_count);
        check_stream(1, f_valid, f_ready, f_data, f_count);
      end
    end
  end

  task automatic set_beat(input logic [LANES-1:0] cs, input bit fl);
    for (int i = 0; i < LANES; i++) begin
      in_data[i*DW +: DW] = seq;
      seq = seq + 16'd1;
    end
    in_case  = cs;
    in_flush = fl;
    in_valid = 1'b1;
  endtask

  task automatic wait_accept(output int waited);
    waited = 0;
    #2;
    while (!in_ready) begin
      @(negedge clk); #2;
      waited++;
    end
    for (int i = 0; i < LANES; i++) begin
      if (in_case[i]) exp_q0.push_back(in_data[i*DW +: DW]);
      else if (split_en) exp_q1.push_back(in_data[i*DW +: DW]);
    end
    if (in_flush) begin
      if (exp_q0.size() != 0) flushed[0] = 1'b1;
      if (exp_q1.size() != 0) flushed[1] = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_flush = 1'b0;
  endtask

  task automatic send(input logic [LANES-1:0] cs, input bit fl, input bit rate_chk);
    int w;
    set_beat(cs, fl);
    wait_accept(w);
    if (rate_chk) chk(w == 0, "R8", "beat stalled with outputs ready", w, 0);
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic run_tests();
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(!t_valid && !f_valid, "R1", "output valid after reset", {t_valid, f_valid}, 0);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);

    // Hit stream only, consumer always ready: carry-over across uneven beats
    rmode = 1; split_en = 1'b0;
    send(8'hFF, 0, 1); send(8'h00, 0, 1); send(8'hA5, 0, 1);
    send(8'h5A, 0, 1); send(8'h81, 0, 1); send(8'h7E, 0, 1);
    send(8'h03, 1, 0);                  // 26 values: 3 full words + 2 (R6)
    drain();
    chk(exp_q0.size() == 0, "R6", "hit values left after flush", exp_q0.size(), 0);

    // All-zero beats with split off: nothing comes out (R5)
    send(8'h00, 0, 1); send(8'h00, 0, 1); send(8'h00, 1, 0);
    repeat (4) begin
      @(negedge clk); #3;
      chk(!t_valid && !f_valid, "R5", "output from all-zero beats", {t_valid, f_valid}, 0);
    end

    // Flush of a word plus seven values, of exactly one word, of nothing (R6)
    send(8'h7F, 0, 1); send(8'hFF, 1, 0); drain();
    send(8'hF0, 0, 1); send(8'h0F, 1, 0); drain();
    send(8'h00, 1, 0); drain();
    chk(exp_q0.size() == 0, "R6", "values stranded by flush", exp_q0.size(), 0);

    // Back-pressure: full word stalls, next beat must be refused (R7)
    rmode = 2;
    send(8'hFF, 0, 0);
    set_beat(8'h3C, 0);
    repeat (3) begin
      @(negedge clk); #2;
      chk(!in_ready, "R7", "beat taken while hit word stalled", in_ready, 0);
      chk(t_valid, "R7", "stalled word lost", t_valid, 1);
    end
    rmode = 1;
    wait_accept(w);
    send(8'h00, 1, 0);
    drain();

    // Split mode with random back-pressure (R2, R4, R7)
    split_en = 1'b1; rmode = 0;
    for (int k = 0; k < 60; k++) send(8'($urandom), 0, 0);
    send(8'($urandom), 1, 0);
    rmode = 1;
    drain();

    // Split mode at full rate (R8)
    for (int k = 0; k < 12; k++) send(8'($urandom), 0, 1);
    send(8'h55, 1, 0);
    drain();
    chk(exp_q0.size() == 0, "R2", "hit values never emitted", exp_q0.size(), 0);
    chk(exp_q1.size() == 0, "R4", "miss values never emitted", exp_q1.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1-watchdog", "run did not finish, cycles", 20000, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule